// File: doc/BRIEF.md
# Streaming Majority Element Voter

This block picks out the value that occurs in more than half of a sequence of words. It reads the sequence once, as a stream, and never stores it. A start pulse loads the element count. The words then arrive on a data input that is qualified by a valid strobe. When the last word has been taken, the block presents the winning value and raises a one-cycle completion strobe.

The voter keeps a single candidate word and a single tally. A word equal to the candidate raises the tally. A different word lowers the tally. Once the tally has reached zero, the next different word replaces the candidate. No second pass confirms the winner. The reported value is therefore guaranteed correct only when a true majority exists. Otherwise it is simply the last surviving candidate.

Top module: `majority_voter`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is all zeros.
- R2: The first word accepted after a start pulse becomes the candidate, and the tally is set to one.
- R3: An accepted word equal to the candidate increments the tally and keeps the candidate.
- R4: An accepted word that differs from the candidate while the tally is zero becomes the new candidate, and the tally returns to one.
- R5: An accepted word that differs from the candidate while the tally is nonzero decrements the tally and leaves the candidate unchanged.
- R6: When the loaded count is 0 or 1, the run ends on the first accepted word, and the result is that word.
- R7: A word is accepted only in a cycle where `in_valid_i` is high and `start_i` is low. Cycles with `in_valid_i` low do not advance the element index.
- R8: `done_o` is high for exactly one cycle: the cycle after the edge that accepts the final word, which is word number max(N,1). In that same cycle `result_o` shows the winner. `result_o` then holds its value until the next completion.
- R9: A start pulse aborts any run in progress. The next accepted word is treated as the first word, and a word that arrives in the same cycle as the start pulse is discarded.
- R10: Words presented while no run is active change neither `done_o` nor `result_o`.
- R11: For the sequence 1,2,2,5,2,2,4,1,2,2 with a count of 10, the result is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a new run and loads `count_i` |
| count_i | input | CW | Number of words in the run |
| in_valid_i | input | 1 | Qualifies `in_data_i` |
| in_data_i | input | DW | Incoming word |
| result_o | output | DW | Winning candidate of the last completed run |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Two situations are hard to reach. The first is a tally that has fallen to exactly zero, followed by a word that differs from the candidate. The second is a restart that lands in the middle of a run, or in the same cycle as a valid word. Short hand-computed vectors reach the first: they alternate values so that the tally cancels to zero just before a newcomer arrives. Directed sequences reach the second: they place the start pulse mid-stream and together with a valid word, then pick the later words so that a voter that ignored the restart would report a different value.

// File: rtl/majority_voter.sv
module majority_voter #(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] count_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic [DW-1:0] result_o,
  output logic          done_o
);

  logic          run_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] need_q;
  logic [DW-1:0] cand_q;
  logic [CW-1:0] tally_q;
  logic [DW-1:0] result_q;
  logic          done_q;

  logic          take;
  logic          first;
  logic          match;
  logic          empty;
  logic          last;
  logic [DW-1:0] cand_nxt;
  logic [CW-1:0] tally_nxt;

  assign take  = run_q & in_valid_i & ~start_i;
  assign first = (idx_q == '0);
  assign match = (in_data_i == cand_q);
  assign empty = (tally_q == '0);
  assign last  = ({1'b0, idx_q} + 1'b1) >= {1'b0, need_q};

  assign cand_nxt = (first || (!match && empty)) ? in_data_i : cand_q;

  always_comb begin
    if (first)       tally_nxt = CW'(1);
    else if (match)  tally_nxt = tally_q + 1'b1;
    else if (empty)  tally_nxt = CW'(1);
    else             tally_nxt = tally_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      idx_q    <= '0;
      need_q   <= '0;
      cand_q   <= '0;
      tally_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q  <= 1'b1;
        idx_q  <= '0;
        need_q <= count_i;
      end else if (take) begin
        cand_q  <= cand_nxt;
        tally_q <= tally_nxt;
        idx_q   <= idx_q + 1'b1;
        if (last) begin
          run_q    <= 1'b0;
          done_q   <= 1'b1;
          result_q <= cand_nxt;
        end
      end
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

endmodule

// File: rtl/majority_voter_chk.sv
module majority_voter_chk #(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [CW-1:0] count_i,
  input logic          in_valid_i,
  input logic [DW-1:0] in_data_i,
  input logic [DW-1:0] result_o,
  input logic          done_o
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= start_i && (count_i <= CW'(1));
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(in_valid_i && !start_i));

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

  p_short_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && in_valid_i && !start_i) |=> (done_o && result_o == $past(in_data_i)));

endmodule

bind majority_voter majority_voter_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
  .in_valid_i(in_valid_i), .in_data_i(in_data_i),
  .result_o(result_o), .done_o(done_o)
);

// File: tb/majority_voter_test.sv
module majority_voter_test;
  localparam int DW = 32;
  localparam int CW = 32;
  localparam int NV = 7;

  localparam logic [31:0] TV [NV][10] = '{
    '{32'd1, 32'd2, 32'd2, 32'd5, 32'd2, 32'd2, 32'd4, 32'd1, 32'd2, 32'd2},
    '{32'd7, 32'd7, 32'd7, 32'd7, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{32'd3, 32'd9, 32'd9, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{32'd4, 32'd4, 32'd8, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{32'd42, 32'd1, 32'd1, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{32'd1, 32'd2, 32'd3, 32'd4, 32'd5, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0},
    '{32'hDEADBEEF, 32'h12345678, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0, 32'd0}
  };
  localparam int          LEN [NV] = '{10, 4, 3, 3, 1, 5, 2};
  localparam logic [31:0] EXP [NV] = '{32'd2, 32'd7, 32'd9, 32'd4, 32'd42, 32'd5, 32'hDEADBEEF};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] count_i = '0;
  logic          in_valid_i = 1'b0;
  logic [DW-1:0] in_data_i = '0;
  logic [DW-1:0] result_o;
  logic          done_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  majority_voter #(.DW(DW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i),
    .result_o(result_o), .done_o(done_o)
  );

  function automatic string tag(int v);
    case (v)
      0: return "R11";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_run(input int n);
    start_i = 1'b1;
    count_i = CW'(n);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    in_valid_i = 1'b1;
    in_data_i  = d;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({31'd0, done_o}, 32'd0, "R1 done");
    check(result_o, 32'd0, "R1 result");
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      start_run(LEN[v]);
      for (int e = 0; e < LEN[v]; e++) begin
        if (v % 2 == 1 && e == 1) @(negedge clk);
        push(TV[v][e]);
        if (e == LEN[v] - 1) begin
          check({31'd0, done_o}, 32'd1, {tag(v), " R8 done"});
          check(result_o, EXP[v], {tag(v), " R2 result"});
        end else begin
          check({31'd0, done_o}, 32'd0, {tag(v), " R7 early done"});
        end
      end
      @(negedge clk);
      check({31'd0, done_o}, 32'd0, "R8 pulse width");
      check(result_o, EXP[v], "R8 hold");
    end

    start_run(0);
    push(32'd55);
    check({31'd0, done_o}, 32'd1, "R6 zero count done");
    check(result_o, 32'd55, "R6 zero count result");

    push(32'd66);
    check({31'd0, done_o}, 32'd0, "R10 idle done");
    check(result_o, 32'd55, "R10 idle result");

    start_run(3);
    push(32'd5);
    push(32'd5);
    start_run(3);
    push(32'd9);
    check({31'd0, done_o}, 32'd0, "R9 no done after restart");
    push(32'd1);
    check({31'd0, done_o}, 32'd0, "R9 no done mid run");
    push(32'd9);
    check({31'd0, done_o}, 32'd1, "R9 done after restart");
    check(result_o, 32'd9, "R9 result after restart");

    start_i = 1'b1;
    count_i = CW'(2);
    in_valid_i = 1'b1;
    in_data_i = 32'd77;
    @(negedge clk);
    start_i = 1'b0;
    in_valid_i = 1'b0;
    push(32'd3);
    check({31'd0, done_o}, 32'd0, "R9 coincident word dropped");
    push(32'd3);
    check({31'd0, done_o}, 32'd1, "R9 coincident done");
    check(result_o, 32'd3, "R9 coincident result");

    repeat (3) push(32'd123);
    check({31'd0, done_o}, 32'd0, "R10 idle after run");
    check(result_o, 32'd3, "R10 result kept");

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule